// File: doc/BRIEF.md
# Partial-Word Load/Store Merge Unit

This unit carries out the four unaligned partial-word memory operations of a 32-bit load/store core: left and right loads, left and right stores. A request brings the operation, the byte address, a register operand and a destination register index. The unit always talks to memory at the word-aligned address. The two address bits that are dropped from that address choose which bytes are merged.

For a load, the returned memory word is shifted and merged into the old register value. The merged value is then offered with a write-enable for the destination register. For a store, the unit runs a read-modify-write. It reads the aligned word, merges the shifted register bytes into it, and writes the merged word back to the same address. No other memory request is issued between the read and the write.

A small sequencer walks each request through the states idle, read, wait, write (stores only) and done. A one-cycle done pulse marks the end of every request.

Top module: `pwm_top`

## Requirements
- R1: The operation code is 0 for load-left, 1 for load-right, 2 for store-left and 3 for store-right. Every memory request carries the request address with bits [1:0] forced to zero. The original bits [1:0] are the byte offset that selects the merge pattern.
- R2: Load-left at offsets 0, 1, 2 and 3 produces (mem << 24) | (reg & 0x00FFFFFF), (mem << 16) | (reg & 0x0000FFFF), (mem << 8) | (reg & 0x000000FF) and mem, in that order.
- R3: Load-right at offsets 0, 1, 2 and 3 produces mem, (mem >> 8) | (reg & 0xFF000000), (mem >> 16) | (reg & 0xFFFF0000) and (mem >> 24) | (reg & 0xFFFFFF00), in that order.
- R4: Store-left at offsets 0, 1, 2 and 3 writes (reg >> 24) | (mem & 0xFFFFFF00), (reg >> 16) | (mem & 0xFFFF0000), (reg >> 8) | (mem & 0xFF000000) and reg, in that order.
- R5: Store-right at offsets 0, 1, 2 and 3 writes reg, (reg << 8) | (mem & 0x000000FF), (reg << 16) | (mem & 0x0000FFFF) and (reg << 24) | (mem & 0x00FFFFFF), in that order.
- R6: A load whose destination index is 0 still issues its memory read and still pulses done, but keeps the register write-enable low.
- R7: A store raises a read request (mem_req=1, mem_we=0) for exactly one cycle. It raises no request while waiting for data. It raises a write request (mem_req=1, mem_we=1) with the merged word in the cycle after mem_rvalid. Done pulses in the following cycle.
- R8: For a load, done, the merged result, the destination index and the write-enable appear in the cycle after mem_rvalid. Done lasts a single cycle whatever the memory latency.
- R9: req_ready is high only when the unit is idle. A request presented while the unit is busy is ignored: it changes neither the memory address nor the result of the request in flight, and it causes no extra memory request.
- R10: After reset, req_ready is 1 and mem_req, done and res_wen are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | Operation code (see R1) |
| req_addr | input | ADDR_W | Byte address |
| req_reg | input | 32 | Register operand: old destination value for loads, store data for stores |
| req_dest | input | 5 | Destination register index |
| req_ready | output | 1 | Unit idle and accepting a request |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_wdata | output | 32 | Merged word to write |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| res_data | output | 32 | Merged word |
| res_dest | output | 5 | Destination index of the completed load |
| res_wen | output | 1 | Register write-enable for the completed load |

## Verification
Every operation is run at all four byte offsets with a register word and a memory word whose bytes are all distinct. Any misplaced lane, wrong shift or wrong keep mask therefore shows up as a wrong byte value. Two different data pairs are used, so a pattern that only happens to match one pair is still caught.

Memory latencies of one and several cycles separate a design that times its output from the request from one that waits for the data strobe. A zero destination index separates suppressing the register write from suppressing the memory read. Keeping junk requests present while a store is in flight shows whether a busy unit wrongly accepts new work.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int WORD_W = 32;
    localparam int LANE_W = 8;
    localparam int REG_AW = 5;

    typedef enum logic [1:0] {
        OP_LOAD_LEFT   = 2'd0,
        OP_LOAD_RIGHT  = 2'd1,
        OP_STORE_LEFT  = 2'd2,
        OP_STORE_RIGHT = 2'd3
    } merge_op_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_WAIT  = 3'd2,
        ST_WRITE = 3'd3,
        ST_DONE  = 3'd4
    } seq_state_e;

    // The store variants take the register as shifted source
    function automatic logic op_is_store(input merge_op_e op);
        return op[1];
    endfunction

    // The left variants count their shift from the top byte
    function automatic logic op_is_left(input merge_op_e op);
        return ~op[0];
    endfunction

    // Load-left and store-right move bytes toward the high end
    function automatic logic op_shifts_up(input merge_op_e op);
        return (op == OP_LOAD_LEFT) || (op == OP_STORE_RIGHT);
    endfunction

endpackage

// File: rtl/pwm_lane_merge.sv
module pwm_lane_merge
    import pwm_pkg::*;
#(
    parameter int W = 32,
    localparam int LANES = W / LANE_W,
    localparam int OFF_W = $clog2(LANES)
) (
    input  merge_op_e        op,
    input  logic [OFF_W-1:0] off,
    input  logic [W-1:0]     reg_word,
    input  logic [W-1:0]     mem_word,
    output logic [W-1:0]     merged
);

    logic [W-1:0]     src;
    logic [W-1:0]     keep;
    logic [W-1:0]     shifted;
    logic [OFF_W-1:0] sh_bytes;
    logic             up;

    always_comb begin
        src      = op_is_store(op) ? reg_word : mem_word;
        keep     = op_is_store(op) ? mem_word : reg_word;
        up       = op_shifts_up(op);
        sh_bytes = op_is_left(op) ? (OFF_W'(LANES - 1) - off) : off;
        if (up) shifted = src << {sh_bytes, 3'b000};
        else    shifted = src >> {sh_bytes, 3'b000};
    end

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic take;
        always_comb begin
            if (up) take = (j >= int'(sh_bytes));
            else    take = (j + int'(sh_bytes) <= LANES - 1);
            merged[j*LANE_W +: LANE_W] = take ? shifted[j*LANE_W +: LANE_W]
                                              : keep[j*LANE_W +: LANE_W];
        end
    end

endmodule

// File: rtl/pwm_seq.sv
module pwm_seq
    import pwm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic is_store,
    input  logic rvalid,
    output logic ready,
    output logic rd_req,
    output logic wr_req,
    output logic data_hit,
    output logic done
);

    seq_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:  if (start) state_nx = ST_READ;
            ST_READ:  state_nx = ST_WAIT;
            ST_WAIT:  if (rvalid) state_nx = is_store ? ST_WRITE : ST_DONE;
            ST_WRITE: state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    assign ready    = (state == ST_IDLE);
    assign rd_req   = (state == ST_READ);
    assign wr_req   = (state == ST_WRITE);
    assign data_hit = (state == ST_WAIT) && rvalid;
    assign done     = (state == ST_DONE);

    assert_read_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req && !wr_req);
    assert_write_then_done_R7: assert property (@(posedge clk) disable iff (rst)
        wr_req |=> done);
    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && ready);
    assert_start_reads_R9: assert property (@(posedge clk) disable iff (rst)
        start |=> rd_req && !ready);

endmodule

// File: rtl/pwm_top.sv
module pwm_top
    import pwm_pkg::*;
#(
    parameter int ADDR_W = 32,
    localparam int LANES = WORD_W / LANE_W,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_reg,
    input  logic [REG_AW-1:0] req_dest,
    output logic              req_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              done,
    output logic [WORD_W-1:0] res_data,
    output logic [REG_AW-1:0] res_dest,
    output logic              res_wen
);

    merge_op_e         cap_op;
    logic [ADDR_W-1:0] cap_addr;
    logic [WORD_W-1:0] cap_reg;
    logic [REG_AW-1:0] cap_dest;
    logic [WORD_W-1:0] merged;
    logic              start, rd_req, wr_req, data_hit;

    assign start = req_valid && req_ready;

    pwm_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .is_store (op_is_store(cap_op)),
        .rvalid   (mem_rvalid),
        .ready    (req_ready),
        .rd_req   (rd_req),
        .wr_req   (wr_req),
        .data_hit (data_hit),
        .done     (done)
    );

    pwm_lane_merge #(.W(WORD_W)) u_merge (
        .op       (cap_op),
        .off      (cap_addr[OFF_W-1:0]),
        .reg_word (cap_reg),
        .mem_word (mem_rdata),
        .merged   (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_op   <= OP_LOAD_LEFT;
            cap_addr <= '0;
            cap_reg  <= '0;
            cap_dest <= '0;
        end else if (start) begin
            cap_op   <= merge_op_e'(req_op);
            cap_addr <= req_addr;
            cap_reg  <= req_reg;
            cap_dest <= req_dest;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_data <= '0;
            res_dest <= '0;
            res_wen  <= 1'b0;
        end else begin
            res_wen <= 1'b0;
            if (data_hit) begin
                res_data <= merged;
                res_dest <= cap_dest;
                res_wen  <= !op_is_store(cap_op) && (cap_dest != '0);
            end
        end
    end

    assign mem_req   = rd_req || wr_req;
    assign mem_we    = wr_req;
    assign mem_addr  = {cap_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign mem_wdata = res_data;

    assert_aligned_addr_R1: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> mem_addr[OFF_W-1:0] == '0);
    assert_no_zero_write_R6: assert property (@(posedge clk) disable iff (rst)
        res_wen |-> (res_dest != '0) && done);
    assert_busy_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> $stable(cap_addr) && $stable(cap_reg));

endmodule

// File: tb/tb_pwm_top.sv
module tb_pwm_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_reg = '0;
    logic [4:0]  req_dest = '0;
    logic        req_ready;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done;
    logic [31:0] res_data;
    logic [4:0]  res_dest;
    logic        res_wen;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    pwm_top dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_reg(req_reg), .req_dest(req_dest),
        .req_ready(req_ready), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .done(done), .res_data(res_data),
        .res_dest(res_dest), .res_wen(res_wen)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input logic [1:0] op, input logic [1:0] off,
                                          input logic [31:0] r, input logic [31:0] m);
        case (op)
            2'd0: case (off)
                2'd0: return (m << 24) | (r & 32'h00FFFFFF);
                2'd1: return (m << 16) | (r & 32'h0000FFFF);
                2'd2: return (m << 8)  | (r & 32'h000000FF);
                default: return m;
            endcase
            2'd1: case (off)
                2'd0: return m;
                2'd1: return (m >> 8)  | (r & 32'hFF000000);
                2'd2: return (m >> 16) | (r & 32'hFFFF0000);
                default: return (m >> 24) | (r & 32'hFFFFFF00);
            endcase
            2'd2: case (off)
                2'd0: return (r >> 24) | (m & 32'hFFFFFF00);
                2'd1: return (r >> 16) | (m & 32'hFFFF0000);
                2'd2: return (r >> 8)  | (m & 32'hFF000000);
                default: return r;
            endcase
            default: case (off)
                2'd0: return r;
                2'd1: return (r << 8)  | (m & 32'h000000FF);
                2'd2: return (r << 16) | (m & 32'h0000FFFF);
                default: return (r << 24) | (m & 32'h00FFFFFF);
            endcase
        endcase
    endfunction

    task automatic run_op(input logic [1:0] op, input logic [31:0] addr,
                          input logic [31:0] rv, input logic [4:0] dst,
                          input logic [31:0] mv, input int lat, input bit spam,
                          input string req);
        logic [31:0] exp;
        logic [31:0] waddr;
        exp   = model(op, addr[1:0], rv, mv);
        waddr = {addr[31:2], 2'b00};
        @(negedge clk);
        chk(req_ready == 1'b1, "R9", "ready when idle", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_op = op; req_addr = addr; req_reg = rv; req_dest = dst;
        @(negedge clk);
        if (spam) begin
            req_op = ~op; req_addr = 32'h0000_0F0F; req_reg = 32'hDEAD_BEEF; req_dest = 5'd9;
        end else begin
            req_valid = 1'b0;
        end
        chk(mem_req && !mem_we, "R7", "read request", {mem_req, mem_we}, 32'h2);
        chk(mem_addr == waddr, "R1", "aligned address", mem_addr, waddr);
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            chk(!mem_req && !done && !req_ready, "R7", "quiet while waiting",
                {mem_req, done, req_ready}, 32'h0);
        end
        mem_rvalid = 1'b1; mem_rdata = mv;
        @(negedge clk);
        mem_rvalid = 1'b0; mem_rdata = 32'h5A5A_5A5A;
        if (op[1]) begin
            chk(mem_req && mem_we, "R7", "write request", {mem_req, mem_we}, 32'h3);
            chk(mem_addr == waddr, "R1", "write address", mem_addr, waddr);
            chk(mem_wdata == exp, req, "stored word", mem_wdata, exp);
            @(negedge clk);
            chk(done == 1'b1, "R7", "done after write", 32'(done), 32'd1);
            chk(res_wen == 1'b0, "R7", "no reg write on store", 32'(res_wen), 32'd0);
        end else begin
            chk(done == 1'b1, "R8", "done after data", 32'(done), 32'd1);
            chk(res_data == exp, req, "loaded word", res_data, exp);
            chk(res_wen == (dst != 5'd0), "R6", "reg write enable",
                32'(res_wen), 32'(dst != 5'd0));
            if (dst != 5'd0) chk(res_dest == dst, "R8", "dest index", 32'(res_dest), 32'(dst));
        end
        req_valid = 1'b0;
        @(negedge clk);
        chk(!done && req_ready && !mem_req && !res_wen, "R8", "single done pulse, back to idle",
            {done, req_ready, mem_req, res_wen}, 32'h4);
    endtask

    task automatic test_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && !mem_req && !done && !res_wen, "R10", "reset state",
            {req_ready, mem_req, done, res_wen}, 32'h8);
    endtask

    task automatic test_load_left;
        for (int off = 0; off < 4; off++) begin
            run_op(2'd0, 32'h0000_0100 + 32'(off), 32'hAABB_CCDD, 5'd3, 32'h1234_5678, 2, 0, "R2");
            run_op(2'd0, 32'h0000_0220 + 32'(off), 32'h0F1E_2D3C, 5'd7, 32'h9687_A5B4, 1, 0, "R2");
        end
    endtask

    task automatic test_load_right;
        for (int off = 0; off < 4; off++) begin
            run_op(2'd1, 32'h0000_0300 + 32'(off), 32'hAABB_CCDD, 5'd4, 32'h1234_5678, 2, 0, "R3");
            run_op(2'd1, 32'h0000_0440 + 32'(off), 32'h0F1E_2D3C, 5'd31, 32'h9687_A5B4, 3, 0, "R3");
        end
    endtask

    task automatic test_store_left;
        for (int off = 0; off < 4; off++) begin
            run_op(2'd2, 32'h0000_0500 + 32'(off), 32'hAABB_CCDD, 5'd0, 32'h1234_5678, 2, 0, "R4");
            run_op(2'd2, 32'h0000_0660 + 32'(off), 32'h0F1E_2D3C, 5'd0, 32'h9687_A5B4, 1, 0, "R4");
        end
    endtask

    task automatic test_store_right;
        for (int off = 0; off < 4; off++) begin
            run_op(2'd3, 32'h0000_0700 + 32'(off), 32'hAABB_CCDD, 5'd0, 32'h1234_5678, 2, 0, "R5");
            run_op(2'd3, 32'h0000_0880 + 32'(off), 32'h0F1E_2D3C, 5'd0, 32'h9687_A5B4, 4, 0, "R5");
        end
    endtask

    task automatic test_zero_dest;
        run_op(2'd0, 32'h0000_0901, 32'h1111_2222, 5'd0, 32'h3344_5566, 2, 0, "R6");
        run_op(2'd1, 32'h0000_0A02, 32'h1111_2222, 5'd0, 32'h3344_5566, 1, 0, "R6");
    endtask

    task automatic test_latency;
        run_op(2'd0, 32'h0000_0B02, 32'hCAFE_F00D, 5'd12, 32'h0102_0304, 1, 0, "R8");
        run_op(2'd1, 32'h0000_0B03, 32'hCAFE_F00D, 5'd13, 32'h0102_0304, 6, 0, "R8");
        run_op(2'd3, 32'h0000_0C01, 32'hCAFE_F00D, 5'd0, 32'h0102_0304, 6, 0, "R7");
    endtask

    task automatic test_busy_ignore;
        run_op(2'd2, 32'h0000_0D01, 32'h89AB_CDEF, 5'd0, 32'h7654_3210, 3, 1, "R9");
        run_op(2'd0, 32'h0000_0E02, 32'h89AB_CDEF, 5'd5, 32'h7654_3210, 2, 1, "R9");
    endtask

    initial begin
        test_reset();
        test_load_left();
        test_load_right();
        test_store_left();
        test_store_right();
        test_zero_dest();
        test_latency();
        test_busy_ignore();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog R7: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule